// File: doc/BRIEF.md
# Double-Buffered Byte DMA Channel Pair

This block is a two-channel memory-to-memory copy engine. Each channel holds its own settings: a source and a destination address, a byte count, a repeat count, a direction and a reload choice for each side, and an enable bit. Software programs these through a narrow register write port and then pulses the channel's trigger line. The engine moves the block one byte at a time over a single-port byte memory bus. Each byte is a read at the working source address followed by a write at the working destination address, and each access waits for the memory's ready. Three status outputs per channel report busy, completed and transfer error.

When both channels are active they share the memory bus and take turns byte by byte. A global mode bit chains the two channels as a double buffer. A channel that completes its whole job sets its partner's enable bit, so the partner is armed and waiting for its own trigger. Clearing a channel's enable while it is moving data stops it at once and leaves the error status, so software can tell an abort apart from a normal completion.

Register selects on `cfg_sel`: 0 source address, 1 destination address, 2 byte count, 3 repeat count, 4 control, 7 global mode. Control bits: bit 0 enable, bit 1 source decrements (0 increments), bit 2 destination decrements, bit 3 source reload, bit 4 destination reload, bit 5 channel reset. Mode bit 0 turns on the double-buffer chaining.

Top module: `dma2_pair`

## Requirements
- R1: After reset every channel shows idle (busy, done and err all 0), `mem_req` is 0, and all settings are zero, so a trigger right after reset starts nothing.
- R2: A trigger starts a channel only when that channel is idle, its enable bit is 1 and its byte count is non-zero. From the cycle after an accepted trigger until the block ends, `busy` is 1 for that channel.
- R3: Each byte is moved as one read (`mem_we`=0) at the working source address and then one write (`mem_we`=1) at the working destination address. The written value is the data returned by the read, and while `mem_ready` is 0 the request, address, direction and write data are held.
- R4: Each side steps by one after every byte, independently: up when its direction bit is 0, down when it is 1.
- R5: A block moves exactly the programmed count of bytes. After the final write the channel shows done=1 and busy=0, and done stays until the next start or reset.
- R6: A repeat count of N makes the channel run N further blocks back to back before it completes. At each block end, a side with reload set returns to its programmed start address, and a side with reload clear carries on from where it stopped.
- R7: A control write with bit 0 = 0 to a busy channel aborts it: err becomes 1, busy and done are 0, and the channel makes no further memory accesses. If the abort arrives in the same cycle as the handshake of the final write, the abort wins: err=1, done=0, and no partner is armed.
- R8: With mode bit 0 set, a channel completing its last block sets the other channel's enable bit. With mode bit 0 clear, a completion leaves the partner's enable unchanged.
- R9: While a channel is busy, writes to its address, count and repeat registers are ignored, and so is a control write with bit 0 = 1. The running block and later triggers use the settings held before the transfer.
- R10: When both channels are busy, their memory writes alternate strictly between the channels.
- R11: A control write with bit 5 = 1 to an idle channel clears all of that channel's settings (addresses, counts, control) to zero and returns its status to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_sel | input | 3 | Register select (0 src, 1 dst, 2 count, 3 repeat, 4 control, 7 mode) |
| cfg_wdata | input | 16 | Register write data |
| trig | input | 2 | Software trigger, one bit per channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle `mem_ready` is 1 |
| mem_ready | input | 1 | Access completes in a cycle where both `mem_req` and `mem_ready` are 1 |
| busy | output | 2 | Channel moving data |
| done | output | 2 | Channel completed its job |
| err | output | 2 | Channel aborted |

## Verification
The delicate coincidence is a software abort landing in the same cycle as the ready handshake of a channel's final write. The completion path and the abort path then both want to set the status. The bench holds `mem_ready` low until the final write is pending, then raises it in the same cycle as the control write that clears enable. It expects error and no completion. It then triggers the partner, which must stay idle because the aborted channel never completed, even though double-buffer mode is on.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int REG_W  = 16;
    localparam int CH_W   = $clog2(NCH);

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_REP  = 3'd3;
    localparam logic [2:0] SEL_CTL  = 3'd4;
    localparam logic [2:0] SEL_MODE = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } stat_e;

    typedef enum logic [1:0] {
        E_IDLE = 2'd0,
        E_RD   = 2'd1,
        E_WR   = 2'd2
    } eng_e;

    // control word, bit 0 is the enable
    typedef struct packed {
        logic wipe;
        logic dst_rld;
        logic src_rld;
        logic dst_dec;
        logic src_dec;
        logic en;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [5:0] w);
        ctl_t c;
        c = ctl_t'(w);
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                     input logic dec);
        return dec ? a - ADDR_W'(1) : a + ADDR_W'(1);
    endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [RW-1:0] wr_data,
    input  logic          trig,
    input  logic          dbuf_on,
    input  logic          partner_fin,
    input  logic          byte_done,
    output stat_e         st,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic          fin
);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [AW-1:0] cfg_src, cfg_dst;
    logic [CW-1:0] cfg_cnt, cfg_rep, w_cnt, w_rep;
    ctl_t          ctl, wctl;
    logic          busy, is_ctl, abort, soft_rst, start, last_byte;
    logic [AW-1:0] nxt_src, nxt_dst;

    assign wctl      = ctl_from_word(wr_data[5:0]);
    assign busy      = (st == ST_BUSY);
    assign is_ctl    = wr_en && (wr_sel == SEL_CTL);
    assign abort     = busy && is_ctl && !wctl.en;
    assign soft_rst  = !busy && is_ctl && wctl.wipe;
    assign start     = !busy && trig && ctl.en && (cfg_cnt != '0);
    assign last_byte = (w_cnt == ONE_C);
    assign nxt_src   = AW'(step_addr(ADDR_W'(src_q), ctl.src_dec));
    assign nxt_dst   = AW'(step_addr(ADDR_W'(dst_q), ctl.dst_dec));

    always_ff @(posedge clk) begin
        fin <= 1'b0;
        if (rst || soft_rst) begin
            cfg_src <= '0;
            cfg_dst <= '0;
            cfg_cnt <= '0;
            cfg_rep <= '0;
            ctl     <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            w_cnt   <= '0;
            w_rep   <= '0;
            st      <= ST_IDLE;
        end else begin
            // settings change only while the channel is not moving data
            if (wr_en && !busy) begin
                case (wr_sel)
                    SEL_SRC: cfg_src <= wr_data[AW-1:0];
                    SEL_DST: cfg_dst <= wr_data[AW-1:0];
                    SEL_CNT: cfg_cnt <= wr_data[CW-1:0];
                    SEL_REP: cfg_rep <= wr_data[CW-1:0];
                    SEL_CTL: begin
                        ctl      <= wctl;
                        ctl.wipe <= 1'b0;
                    end
                    default: ;
                endcase
            end

            if (abort) begin
                st     <= ST_ERR;
                ctl.en <= 1'b0;
            end else if (busy && byte_done) begin
                if (last_byte) begin
                    src_q <= ctl.src_rld ? cfg_src : nxt_src;
                    dst_q <= ctl.dst_rld ? cfg_dst : nxt_dst;
                    if (w_rep != '0) begin
                        w_rep <= w_rep - ONE_C;
                        w_cnt <= cfg_cnt;
                    end else begin
                        w_cnt <= '0;
                        st    <= ST_DONE;
                        fin   <= 1'b1;
                    end
                end else begin
                    src_q <= nxt_src;
                    dst_q <= nxt_dst;
                    w_cnt <= w_cnt - ONE_C;
                end
            end else if (start) begin
                src_q <= cfg_src;
                dst_q <= cfg_dst;
                w_cnt <= cfg_cnt;
                w_rep <= cfg_rep;
                st    <= ST_BUSY;
            end

            if (dbuf_on && partner_fin) begin
                ctl.en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
    import dma2_pkg::*;
(
    input  logic [NCH-1:0]  req,
    input  logic [CH_W-1:0] last,
    output logic [CH_W-1:0] pick,
    output logic            any
);
    // two requesters: the one not served last wins a tie
    always_comb begin
        any = |req;
        if (req[0] && req[1]) begin
            pick = ~last;
        end else begin
            pick = req[1] ? CH_W'(1) : CH_W'(0);
        end
    end
endmodule

// File: rtl/dma2_eng.sv
module dma2_eng
    import dma2_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         busy,
    input  logic [NCH-1:0][AW-1:0] src_vec,
    input  logic [NCH-1:0][AW-1:0] dst_vec,
    input  logic [CH_W-1:0]        pick,
    input  logic                   any,
    output logic [CH_W-1:0]        last,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic [DW-1:0]          mem_rdata,
    input  logic                   mem_ready,
    output logic [NCH-1:0]         byte_done
);
    eng_e            es;
    logic [CH_W-1:0] cur;
    logic [DW-1:0]   hold;
    logic            live;

    assign live = busy[cur];

    always_comb begin
        mem_req   = (es != E_IDLE) && live;
        mem_we    = (es == E_WR);
        mem_addr  = (es == E_WR) ? dst_vec[cur] : src_vec[cur];
        mem_wdata = hold;
        byte_done = '0;
        if ((es == E_WR) && live && mem_ready) begin
            byte_done[cur] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            es   <= E_IDLE;
            cur  <= '0;
            last <= CH_W'(NCH - 1);
            hold <= '0;
        end else begin
            case (es)
                E_IDLE: begin
                    if (any) begin
                        cur <= pick;
                        es  <= E_RD;
                    end
                end
                E_RD: begin
                    if (!live) begin
                        es <= E_IDLE;
                    end else if (mem_ready) begin
                        hold <= mem_rdata;
                        es   <= E_WR;
                    end
                end
                E_WR: begin
                    if (!live) begin
                        es <= E_IDLE;
                    end else if (mem_ready) begin
                        last <= cur;
                        es   <= E_IDLE;
                    end
                end
                default: es <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma2_pair.sv
module dma2_pair
    import dma2_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_ch,
    input  logic [2:0]    cfg_sel,
    input  logic [RW-1:0] cfg_wdata,
    input  logic [1:0]    trig,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic [1:0]    busy,
    output logic [1:0]    done,
    output logic [1:0]    err
);
    logic                   dbuf_on;
    logic [NCH-1:0]         fin, byte_done;
    logic [NCH-1:0][AW-1:0] src_vec, dst_vec;
    logic [CH_W-1:0]        pick, last;
    logic                   any;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbuf_on <= 1'b0;
        end else if (cfg_we && (cfg_sel == SEL_MODE)) begin
            dbuf_on <= cfg_wdata[0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        stat_e st;

        dma2_chan #(.AW(AW), .CW(CW), .RW(RW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (cfg_we && (cfg_ch == CH_W'(g))),
            .wr_sel     (cfg_sel),
            .wr_data    (cfg_wdata),
            .trig       (trig[g]),
            .dbuf_on    (dbuf_on),
            .partner_fin(fin[NCH-1-g]),
            .byte_done  (byte_done[g]),
            .st         (st),
            .src_q      (src_vec[g]),
            .dst_q      (dst_vec[g]),
            .fin        (fin[g])
        );

        assign busy[g] = (st == ST_BUSY);
        assign done[g] = (st == ST_DONE);
        assign err[g]  = (st == ST_ERR);
    end

    dma2_arb u_arb (
        .req (busy),
        .last(last),
        .pick(pick),
        .any (any)
    );

    dma2_eng #(.AW(AW), .DW(DW)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .src_vec  (src_vec),
        .dst_vec  (dst_vec),
        .pick     (pick),
        .any      (any),
        .last     (last),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_ready(mem_ready),
        .byte_done(byte_done)
    );
endmodule

// File: rtl/dma2_pair_chk.sv
module dma2_pair_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        cfg_ch,
    input logic [2:0]  cfg_sel,
    input logic        ctl_en_bit,
    input logic [1:0]  trig,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ready,
    input logic [1:0]  busy,
    input logic [1:0]  done,
    input logic [1:0]  err
);
    // R3: a stalled access is held unchanged
    p_hold_access_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && !cfg_we) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: a channel becomes busy only after its trigger
    p_start_ch0_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy[0]) |-> $past(trig[0]));

    p_start_ch1_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy[1]) |-> $past(trig[1]));

    // R7: error appears only after an enable-clearing control write
    p_abort_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err[0]) |-> $past(cfg_we && !cfg_ch && (cfg_sel == 3'd4) && !ctl_en_bit));

    // R5: completion follows a finished write handshake
    p_done_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done[0]) |-> $past(mem_req && mem_we && mem_ready));

    p_done1_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done[1]) |-> $past(mem_req && mem_we && mem_ready));
endmodule

bind dma2_pair dma2_pair_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_sel   (cfg_sel),
    .ctl_en_bit(cfg_wdata[0]),
    .trig      (trig),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/dma2_pair_test.sv
`timescale 1ns/1ps
module dma2_pair_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_ch = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [1:0]  trig = 2'b00;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [1:0]  busy, done, err;

    int          nchk = 0;
    int          nfail = 0;
    int          rmode = 0;
    logic        man_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          epoch = 1;
    int          wn = 0;
    logic [7:0]  dmem [0:4095];
    logic [7:0]  dtag [0:4095];
    logic [15:0] wlog [0:255];

    always #2.5 clk = ~clk;

    dma2_pair uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .trig(trig), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .err(err)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: reads return a fixed pattern, writes land in a tagged store
    assign mem_rdata = pat(mem_addr);
    assign mem_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (lfsr[0] | lfsr[3]) : man_ready;

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) begin
            dmem[mem_addr[11:0]] <= mem_wdata;
            dtag[mem_addr[11:0]] <= epoch[7:0];
            wlog[wn[7:0]]        <= mem_addr;
            wn                   <= wn + 1;
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wreg(input int ch, input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch[0]; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [15:0] s, input logic [15:0] d,
                        input logic [15:0] cnt, input logic [15:0] rep, input logic [15:0] ctl);
        wreg(ch, 3'd0, s);
        wreg(ch, 3'd1, d);
        wreg(ch, 3'd2, cnt);
        wreg(ch, 3'd3, rep);
        wreg(ch, 3'd4, ctl);
    endtask

    task automatic pulse(input logic [1:0] t);
        @(negedge clk);
        trig = t;
        @(negedge clk);
        trig = 2'b00;
    endtask

    task automatic wait_idle(input int ch);
        for (int i = 0; i < 3000 && busy[ch]; i++) @(negedge clk);
    endtask

    // number of bytes of a copy that did not land as expected in this epoch
    function automatic int copy_errs(input logic [15:0] s0, input logic [15:0] d0, input int cnt,
                                     input logic sdec, input logic ddec);
        int bad = 0;
        for (int k = 0; k < cnt; k++) begin
            logic [15:0] sa, da;
            sa = sdec ? s0 - 16'(k) : s0 + 16'(k);
            da = ddec ? d0 - 16'(k) : d0 + 16'(k);
            if (dtag[da[11:0]] !== epoch[7:0] || dmem[da[11:0]] !== pat(sa)) bad++;
        end
        return bad;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and cleared settings
        chk(busy == 2'b00 && done == 2'b00 && err == 2'b00, "R1 status after reset", {busy, done, err}, 0);
        chk(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);
        pulse(2'b11);
        chk(busy == 2'b00, "R1 trigger with cleared settings", busy, 0);

        // R3 R4 R5: sweep channel, directions, counts and ready pattern
        for (int ch = 0; ch < 2; ch++)
            for (int dir = 0; dir < 4; dir++)
                for (int ci = 0; ci < 3; ci++)
                    for (int rm = 0; rm < 2; rm++) begin
                        int          cnt;
                        logic [15:0] s0, d0;
                        cnt   = (ci == 0) ? 1 : (ci == 1) ? 3 : 6;
                        s0    = 16'h0400 + 16'(ch * 64);
                        d0    = 16'h0800 + 16'(ch * 64);
                        rmode = rm;
                        epoch++;
                        prog(ch, s0, d0, 16'(cnt), 16'd0, 16'(1 | (dir << 1)));
                        w0 = wn;
                        pulse(2'b01 << ch);
                        chk(busy[ch] == 1'b1, "R2 busy after trigger", busy, 2'b01 << ch);
                        wait_idle(ch);
                        chk(done[ch] && !err[ch], "R5 done after block", {done, err}, 0);
                        chk(wn - w0 == cnt, "R5 byte count", wn - w0, cnt);
                        chk(copy_errs(s0, d0, cnt, dir[0], dir[1]) == 0, "R4 R3 copied bytes",
                            copy_errs(s0, d0, cnt, dir[0], dir[1]), 0);
                    end

        // R6: repeats with source reload, destination carrying on
        rmode = 1;
        epoch++;
        prog(1, 16'h0300, 16'h0A00, 16'd3, 16'd2, 16'h0009);
        w0 = wn;
        pulse(2'b10);
        wait_idle(1);
        chk(wn - w0 == 9, "R6 repeat writes", wn - w0, 9);
        begin
            int bad = 0;
            for (int k = 0; k < 9; k++)
                if (dmem[12'hA00 + 12'(k)] !== pat(16'h0300 + 16'(k % 3))) bad++;
            chk(bad == 0 && done[1], "R6 source reload contents", bad, 0);
        end

        // R6: destination reload, source carrying on
        epoch++;
        prog(1, 16'h0310, 16'h0B00, 16'd2, 16'd1, 16'h0011);
        w0 = wn;
        pulse(2'b10);
        wait_idle(1);
        chk(wn - w0 == 4, "R6 reload writes", wn - w0, 4);
        chk(dmem[12'hB00] === pat(16'h0312) && dmem[12'hB01] === pat(16'h0313)
            && dtag[12'hB02] !== epoch[7:0], "R6 destination reload contents", dmem[12'hB00], pat(16'h0312));

        // R7: abort in mid-block
        epoch++;
        prog(0, 16'h0100, 16'h0C00, 16'd40, 16'd0, 16'h0001);
        pulse(2'b01);
        repeat (10) @(negedge clk);
        chk(busy[0] == 1'b1, "R7 busy before abort", busy, 1);
        wreg(0, 3'd4, 16'h0000);
        chk(err[0] && !busy[0] && !done[0], "R7 error after abort", {busy, done, err}, 1);
        w0 = wn;
        repeat (12) @(negedge clk);
        chk(wn == w0 && !mem_req, "R7 no access after abort", wn - w0, 0);

        // R7: abort coinciding with the final write handshake, chaining on
        rmode = 2;
        man_ready = 1'b0;
        wreg(0, 3'd7, 16'h0001);
        prog(1, 16'h0200, 16'h0D00, 16'd2, 16'd0, 16'h0000);
        prog(0, 16'h0210, 16'h0D80, 16'd1, 16'd0, 16'h0001);
        pulse(2'b01);
        @(negedge clk);
        man_ready = 1'b1;
        @(negedge clk);
        man_ready = 1'b0;
        for (int i = 0; i < 20 && !(mem_req && mem_we); i++) @(negedge clk);
        chk(mem_req && mem_we, "R7 final write pending", {mem_req, mem_we}, 3);
        man_ready = 1'b1;
        cfg_we = 1'b1; cfg_ch = 1'b0; cfg_sel = 3'd4; cfg_wdata = 16'h0000;
        @(negedge clk);
        cfg_we = 1'b0;
        man_ready = 1'b0;
        chk(err[0] && !done[0], "R7 abort wins over completion", {done[0], err[0]}, 1);
        pulse(2'b10);
        chk(busy[1] == 1'b0, "R7 partner not armed by abort", busy, 0);

        // R8: double-buffer chaining
        rmode = 0;
        prog(0, 16'h0220, 16'h0E00, 16'd3, 16'd0, 16'h0001);
        prog(1, 16'h0230, 16'h0E40, 16'd3, 16'd0, 16'h0000);
        pulse(2'b10);
        chk(busy[1] == 1'b0, "R2 disabled channel ignores trigger", busy, 0);
        pulse(2'b01);
        wait_idle(0);
        wreg(0, 3'd4, 16'h0000);
        pulse(2'b10);
        chk(busy[1] == 1'b1, "R8 partner armed by completion", busy, 2);
        wait_idle(1);
        pulse(2'b01);
        chk(busy[0] == 1'b1, "R8 channel re-armed by partner", busy, 1);
        wait_idle(0);
        wreg(0, 3'd7, 16'h0000);
        wreg(1, 3'd4, 16'h0000);
        pulse(2'b01);
        wait_idle(0);
        pulse(2'b10);
        chk(busy[1] == 1'b0, "R8 no chaining with mode clear", busy, 0);

        // R9: writes to a busy channel are ignored
        rmode = 1;
        epoch++;
        prog(0, 16'h0100, 16'h0900, 16'd8, 16'd0, 16'h0001);
        w0 = wn;
        pulse(2'b01);
        wreg(0, 3'd1, 16'h0F00);
        wreg(0, 3'd2, 16'd2);
        wreg(0, 3'd4, 16'h0005);
        chk(busy[0] == 1'b1, "R9 still busy after writes", busy, 1);
        wait_idle(0);
        chk(wn - w0 == 8 && copy_errs(16'h0100, 16'h0900, 8, 1'b0, 1'b0) == 0,
            "R9 block unchanged", wn - w0, 8);
        epoch++;
        w0 = wn;
        pulse(2'b01);
        wait_idle(0);
        chk(wn - w0 == 8 && copy_errs(16'h0100, 16'h0900, 8, 1'b0, 1'b0) == 0,
            "R9 settings kept for next start", wn - w0, 8);

        // R10: both channels busy alternate writes
        epoch++;
        prog(0, 16'h0140, 16'h0300, 16'd4, 16'd0, 16'h0001);
        prog(1, 16'h0180, 16'h0600, 16'd4, 16'd0, 16'h0001);
        w0 = wn;
        pulse(2'b11);
        wait_idle(0);
        wait_idle(1);
        chk(wn - w0 == 8, "R10 total writes", wn - w0, 8);
        begin
            int same = 0;
            for (int k = 1; k < 8; k++)
                if (wlog[8'(w0 + k)][10:8] == wlog[8'(w0 + k - 1)][10:8]) same++;
            chk(same == 0, "R10 strict alternation", same, 0);
        end
        chk(copy_errs(16'h0140, 16'h0300, 4, 1'b0, 1'b0) == 0 &&
            copy_errs(16'h0180, 16'h0600, 4, 1'b0, 1'b0) == 0, "R10 contents", 1, 0);

        // R11: channel reset clears status and settings
        chk(done[0] == 1'b1, "R5 done held until reset", done, 1);
        wreg(0, 3'd4, 16'h0020);
        chk(!done[0] && !err[0] && !busy[0], "R11 status idle after channel reset", {done, err}, 0);
        pulse(2'b01);
        chk(busy[0] == 1'b0, "R11 enable cleared", busy, 0);
        wreg(0, 3'd4, 16'h0001);
        pulse(2'b01);
        chk(busy[0] == 1'b0, "R11 count cleared", busy, 0);
        epoch++;
        wreg(0, 3'd2, 16'd1);
        w0 = wn;
        pulse(2'b01);
        wait_idle(0);
        chk(wn - w0 == 1 && wlog[8'(w0)] == 16'h0000 && dmem[0] === pat(16'h0000),
            "R11 addresses cleared", wlog[8'(w0)], 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule